// File: doc/BRIEF.md
# Interrupt File Indirect Access Router

This block sits between a hart's indirect register window and a set of interrupt-file pages. Each request carries a privilege level, a virtualization flag, a guest index, a register select, an access width (32 or 64 bits), write data and a write mask. The router works out which page the request targets, or rejects it. It then decodes the select into one of these operations: the delivery enable, the priority threshold, the pending arrays or the enable arrays. It returns the value that was there before the write and applies the masked write at the same clock edge.

A separate strobe selects the top-interrupt register. The highest-priority search lives outside this block. It sees the page currently addressed on `page_o` and answers on `top_id`. The router hands that value back as read data, and a write through this port clears the matching pending bit. All page state is also exposed to the search logic as flat vectors.

The parameter `MMODE` chooses between a machine-level instance and a supervisor-level instance. A machine-level instance has a single page. A supervisor-level instance can also host guest pages.

Top module: `irr_router`

## Requirements
- R1: With MMODE=1, a request is legal only at machine privilege (req_priv=2'b11) with req_virt=0, and it targets page 0. Any other privilege, or virt=1, is an error.
- R2: With MMODE=0, only supervisor privilege (req_priv=2'b01) is legal. A non-virtualised request targets page 0, and `page_o` shows the targeted page while the request is held.
- R3: With MMODE=0, a virtualised supervisor request targets page `req_guest`. A guest index of zero, or one at or above PAGES, is an error.
- R4: Select 0x70 is the delivery flag (data bit 0) and select 0x72 is the threshold (low $clog2(IDS)+1 bits). A select outside 0x70, 0x72 and 0x80–0xFF is an error. Any error returns zero read data and changes no state.
- R5: Selects 0x80–0xBF address pending words and 0xC0–0xFF address enable words, with n = select[5:0]. A 32-bit access to word n covers identities 32n to 32n+31, and read bit i is identity 32n+i.
- R6: On a 64-bit access, an odd n is an error. An even n covers identities 32n to 32n+63.
- R7: A word is an error when its index, after halving for 64-bit accesses, is at or above IDS divided by the access width.
- R8: Reads return the value held before the access. A write changes only the bits set in the effective write mask, and each such bit takes the value of the matching write-data bit.
- R9: Identity 0 is never pending or enabled. Its bit reads as zero, and writes to it are discarded.
- R10: When req_top=1, req_sel is ignored and the read data is `top_id` zero-extended. If the effective mask is non-zero and top_id is non-zero, the pending bit of that identity on the addressed page is cleared.
- R11: rsp_valid is high in exactly the cycle after each req_valid, and state changes at that same edge. A 32-bit access ignores mask bits 63:32 and returns zero in read bits 63:32.
- R12: After reset, all pending, enable, delivery and threshold state is zero and rsp_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request strobe |
| req_priv | input | 2 | Privilege level (00 user, 01 supervisor, 11 machine) |
| req_virt | input | 1 | Virtualised access flag |
| req_guest | input | GUEST_W | Guest page index |
| req_top | input | 1 | Selects the top-interrupt register |
| req_sel | input | 8 | Register select |
| req_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| req_wdata | input | 64 | Write data |
| req_wmask | input | 64 | Write mask |
| top_id | input | $clog2(IDS) | Top identity for the page on page_o, from the search logic |
| page_o | output | PW | Page addressed by the current request |
| rsp_valid | output | 1 | Response strobe |
| rsp_err | output | 1 | Illegal access |
| rsp_rdata | output | 64 | Read data (old value) |
| deliver_o | output | PAGES | Delivery flag per page |
| thresh_o | output | PAGES*($clog2(IDS)+1) | Threshold per page, page 0 lowest |
| pend_o | output | PAGES*IDS | Pending bits, bit p*IDS+id |
| en_o | output | PAGES*IDS | Enable bits, bit p*IDS+id |

## Verification
The hardest situations to reach are the ones where legality depends on two fields at once. Examples are a wide access to an odd index, or an index that fits at 32 bits but not at 64 bits. The bench drives both a supervisor-level and a machine-level instance with the same stimulus, so every legality decision is made under both configurations in the same cycle. Directed accesses aim at the word boundary (index IDS/32 and index IDS/64·2), at guest indices 0 and PAGES, and at the top port with a zero and a non-zero identity. A long run of random selects, privileges and masks is then compared against the reference model on every response.

// File: rtl/irr_pkg.sv
package irr_pkg;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_DELIV,
        OP_THRESH,
        OP_TOP,
        OP_PEND,
        OP_EN
    } op_e;

    localparam logic [1:0] PRIV_U = 2'b00;
    localparam logic [1:0] PRIV_S = 2'b01;
    localparam logic [1:0] PRIV_M = 2'b11;

    localparam logic [7:0] SEL_DELIV  = 8'h70;
    localparam logic [7:0] SEL_THRESH = 8'h72;

    typedef struct packed {
        logic       ok;
        op_e        op;
        logic [5:0] word;
    } sel_dec_t;

    // Effective mask: upper half dropped on narrow accesses
    function automatic logic [63:0] eff_mask(logic wide, logic [63:0] m);
        return wide ? m : {32'h0, m[31:0]};
    endfunction

endpackage

// File: rtl/irr_page_sel.sv
module irr_page_sel #(
    parameter bit MMODE   = 1'b0,
    parameter int PAGES   = 4,
    parameter int GUEST_W = 6,
    localparam int PW     = (PAGES > 1) ? $clog2(PAGES) : 1
) (
    input  logic [1:0]         priv,
    input  logic               virt,
    input  logic [GUEST_W-1:0] guest,
    output logic               ok,
    output logic [PW-1:0]      page
);
    import irr_pkg::*;

    always_comb begin
        ok   = 1'b0;
        page = '0;
        if (MMODE) begin
            ok = (priv == PRIV_M) && !virt;
        end else if (priv == PRIV_S) begin
            if (virt) begin
                ok   = (guest != '0) && (int'(guest) < PAGES);
                page = guest[PW-1:0];
            end else begin
                ok = 1'b1;
            end
        end
    end
endmodule

// File: rtl/irr_sel_dec.sv
module irr_sel_dec #(
    parameter int IDS = 128
) (
    input  logic             top,
    input  logic [7:0]       sel,
    input  logic             wide,
    output irr_pkg::sel_dec_t dec
);
    import irr_pkg::*;

    localparam int WORDS32 = IDS / 32;
    localparam int WORDS64 = IDS / 64;

    logic [5:0] idx;
    assign idx = sel[5:0];

    always_comb begin
        dec = '{ok: 1'b0, op: OP_NONE, word: 6'd0};
        if (top) begin
            dec.ok = 1'b1;
            dec.op = OP_TOP;
        end else if (sel == SEL_DELIV) begin
            dec.ok = 1'b1;
            dec.op = OP_DELIV;
        end else if (sel == SEL_THRESH) begin
            dec.ok = 1'b1;
            dec.op = OP_THRESH;
        end else if (sel[7]) begin
            dec.op = sel[6] ? OP_EN : OP_PEND;
            if (wide) begin
                dec.word = {1'b0, idx[5:1]};
                dec.ok   = !idx[0] && (int'(idx[5:1]) < WORDS64);
            end else begin
                dec.word = idx;
                dec.ok   = int'(idx) < WORDS32;
            end
        end
    end
endmodule

// File: rtl/irr_state.sv
module irr_state #(
    parameter int PAGES = 4,
    parameter int IDS   = 128,
    localparam int PW    = (PAGES > 1) ? $clog2(PAGES) : 1,
    localparam int IDX_W = $clog2(IDS),
    localparam int ID_W  = IDX_W + 1,
    localparam int TOTAL = PAGES * IDS
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  irr_pkg::op_e          op,
    input  logic [PW-1:0]         page,
    input  logic [5:0]            word,
    input  logic                  wide,
    input  logic [63:0]           wdata,
    input  logic [63:0]           wmask,
    input  logic [IDX_W-1:0]      top_id,
    output logic [63:0]           rdata,
    output logic [PAGES-1:0]      deliver,
    output logic [PAGES*ID_W-1:0] thresh,
    output logic [TOTAL-1:0]      pend,
    output logic [TOTAL-1:0]      en
);
    import irr_pkg::*;

    logic [PAGES-1:0]            dl_q, dl_n;
    logic [PAGES-1:0][ID_W-1:0]  th_q, th_n;
    logic [TOTAL-1:0]            pd_q, pd_n, en_q, en_n;
    logic [63:0]                 m;
    int                          width, base, b;

    assign m     = eff_mask(wide, wmask);
    assign width = wide ? 64 : 32;
    assign base  = int'(page) * IDS + int'(word) * width;

    // Read path: pre-edge state, so reads see the old value
    always_comb begin
        rdata = '0;
        b     = 0;
        unique case (op)
            OP_DELIV:  rdata[0] = dl_q[page];
            OP_THRESH: rdata[ID_W-1:0] = th_q[page];
            OP_TOP:    rdata[IDX_W-1:0] = top_id;
            OP_PEND, OP_EN: begin
                for (int i = 0; i < 64; i++) begin
                    b = base + i;
                    if (i < width && b < TOTAL)
                        rdata[i] = (op == OP_PEND) ? pd_q[b] : en_q[b];
                end
            end
            default: rdata = '0;
        endcase
    end

    // Next-state computation
    always_comb begin
        dl_n = dl_q;
        th_n = th_q;
        pd_n = pd_q;
        en_n = en_q;
        if (we) begin
            unique case (op)
                OP_DELIV: if (m[0]) dl_n[page] = wdata[0];
                OP_THRESH: th_n[page] = (th_q[page] & ~m[ID_W-1:0]) |
                                        (wdata[ID_W-1:0] & m[ID_W-1:0]);
                OP_TOP: if (m != '0 && top_id != '0)
                    pd_n[int'(page) * IDS + int'(top_id)] = 1'b0;
                OP_PEND, OP_EN: begin
                    for (int i = 0; i < 64; i++) begin
                        if (i < width && m[i] && (base + i) < TOTAL &&
                            !(word == 6'd0 && i == 0)) begin
                            if (op == OP_PEND) pd_n[base + i] = wdata[i];
                            else               en_n[base + i] = wdata[i];
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dl_q <= '0;
            th_q <= '0;
            pd_q <= '0;
            en_q <= '0;
        end else begin
            dl_q <= dl_n;
            th_q <= th_n;
            pd_q <= pd_n;
            en_q <= en_n;
        end
    end

    assign deliver = dl_q;
    assign thresh  = th_q;
    assign pend    = pd_q;
    assign en      = en_q;
endmodule

// File: rtl/irr_router.sv
module irr_router #(
    parameter bit MMODE   = 1'b0,
    parameter int PAGES   = 4,
    parameter int IDS     = 128,
    parameter int GUEST_W = 6,
    localparam int PW     = (PAGES > 1) ? $clog2(PAGES) : 1,
    localparam int IDX_W  = $clog2(IDS),
    localparam int ID_W   = IDX_W + 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    input  logic [1:0]            req_priv,
    input  logic                  req_virt,
    input  logic [GUEST_W-1:0]    req_guest,
    input  logic                  req_top,
    input  logic [7:0]            req_sel,
    input  logic                  req_wide,
    input  logic [63:0]           req_wdata,
    input  logic [63:0]           req_wmask,
    input  logic [IDX_W-1:0]      top_id,
    output logic [PW-1:0]         page_o,
    output logic                  rsp_valid,
    output logic                  rsp_err,
    output logic [63:0]           rsp_rdata,
    output logic [PAGES-1:0]      deliver_o,
    output logic [PAGES*ID_W-1:0] thresh_o,
    output logic [PAGES*IDS-1:0]  pend_o,
    output logic [PAGES*IDS-1:0]  en_o
);
    import irr_pkg::*;

    logic      pg_ok, commit;
    sel_dec_t  dec;
    logic [63:0] rd;

    irr_page_sel #(.MMODE(MMODE), .PAGES(PAGES), .GUEST_W(GUEST_W)) u_page (
        .priv (req_priv),
        .virt (req_virt),
        .guest(req_guest),
        .ok   (pg_ok),
        .page (page_o)
    );

    irr_sel_dec #(.IDS(IDS)) u_dec (
        .top (req_top),
        .sel (req_sel),
        .wide(req_wide),
        .dec (dec)
    );

    assign commit = req_valid && pg_ok && dec.ok;

    irr_state #(.PAGES(PAGES), .IDS(IDS)) u_state (
        .clk    (clk),
        .rst    (rst),
        .we     (commit),
        .op     (dec.op),
        .page   (page_o),
        .word   (dec.word),
        .wide   (req_wide),
        .wdata  (req_wdata),
        .wmask  (req_wmask),
        .top_id (top_id),
        .rdata  (rd),
        .deliver(deliver_o),
        .thresh (thresh_o),
        .pend   (pend_o),
        .en     (en_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= req_valid && !commit;
            rsp_rdata <= commit ? rd : '0;
        end
    end
endmodule

// File: rtl/irr_chk.sv
module irr_chk #(
    parameter int PAGES = 4,
    parameter int IDS   = 128,
    parameter int ID_W  = 8
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  req_valid,
    input logic [1:0]            req_priv,
    input logic                  req_wide,
    input logic                  rsp_valid,
    input logic                  rsp_err,
    input logic [63:0]           rsp_rdata,
    input logic [PAGES-1:0]      deliver_o,
    input logic [PAGES*ID_W-1:0] thresh_o,
    input logic [PAGES*IDS-1:0]  pend_o,
    input logic [PAGES*IDS-1:0]  en_o
);
    logic [PAGES*IDS-1:0] id0_bits;
    always_comb begin
        id0_bits = '0;
        for (int p = 0; p < PAGES; p++) id0_bits[p*IDS] = 1'b1;
    end

    // R11
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    // R11
    rsp_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);
    // R4
    err_zero_data_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_err) |-> rsp_rdata == 64'h0);
    // R4
    err_no_change_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_err) |-> ($stable(pend_o) && $stable(en_o) &&
                                    $stable(deliver_o) && $stable(thresh_o)));
    // R11
    narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !$past(req_wide)) |-> rsp_rdata[63:32] == 32'h0);
    // R9
    id0_never_set_chk: assert property (@(posedge clk) disable iff (rst)
        ((pend_o | en_o) & id0_bits) == '0);
    // R1
    user_priv_err_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_priv == 2'b00) |=> rsp_err);
    // R11
    idle_no_change_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> ($stable(pend_o) && $stable(en_o)));
endmodule

bind irr_router irr_chk #(.PAGES(PAGES), .IDS(IDS), .ID_W(ID_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_priv (req_priv),
    .req_wide (req_wide),
    .rsp_valid(rsp_valid),
    .rsp_err  (rsp_err),
    .rsp_rdata(rsp_rdata),
    .deliver_o(deliver_o),
    .thresh_o (thresh_o),
    .pend_o   (pend_o),
    .en_o     (en_o)
);

// File: tb/tb_irr_router.sv
module tb_irr_router;
    localparam int CLK_PERIOD = 10;
    localparam int PAGES   = 4;
    localparam int IDS     = 128;
    localparam int GUEST_W = 6;
    localparam int PW      = $clog2(PAGES);
    localparam int IDX_W   = $clog2(IDS);
    localparam int ID_W    = IDX_W + 1;
    localparam int TOTAL   = PAGES * IDS;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic [1:0] req_priv = '0;
    logic req_virt = 1'b0;
    logic [GUEST_W-1:0] req_guest = '0;
    logic req_top = 1'b0;
    logic [7:0] req_sel = '0;
    logic req_wide = 1'b0;
    logic [63:0] req_wdata = '0, req_wmask = '0;
    logic [IDX_W-1:0] top_id = '0;

    logic [PW-1:0]         page_s, page_m;
    logic                  rv_s, rv_m, re_s, re_m;
    logic [63:0]           rd_s, rd_m;
    logic [PAGES-1:0]      dl_s, dl_m;
    logic [PAGES*ID_W-1:0] th_s, th_m;
    logic [TOTAL-1:0]      pd_s, pd_m, en_s, en_m;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irr_router #(.MMODE(1'b0), .PAGES(PAGES), .IDS(IDS), .GUEST_W(GUEST_W)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_priv(req_priv),
        .req_virt(req_virt), .req_guest(req_guest), .req_top(req_top),
        .req_sel(req_sel), .req_wide(req_wide), .req_wdata(req_wdata),
        .req_wmask(req_wmask), .top_id(top_id), .page_o(page_s),
        .rsp_valid(rv_s), .rsp_err(re_s), .rsp_rdata(rd_s),
        .deliver_o(dl_s), .thresh_o(th_s), .pend_o(pd_s), .en_o(en_s));

    irr_router #(.MMODE(1'b1), .PAGES(PAGES), .IDS(IDS), .GUEST_W(GUEST_W)) dut_m (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_priv(req_priv),
        .req_virt(req_virt), .req_guest(req_guest), .req_top(req_top),
        .req_sel(req_sel), .req_wide(req_wide), .req_wdata(req_wdata),
        .req_wmask(req_wmask), .top_id(top_id), .page_o(page_m),
        .rsp_valid(rv_m), .rsp_err(re_m), .rsp_rdata(rd_m),
        .deliver_o(dl_m), .thresh_o(th_m), .pend_o(pd_m), .en_o(en_m));

    // Reference model: [config 0 = supervisor, 1 = machine]
    bit              m_arr [2][2][TOTAL];   // [cfg][0 pend / 1 enable][bit]
    bit              m_dl  [2][PAGES];
    logic [ID_W-1:0] m_th  [2][PAGES];

    task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic model(int c, logic [1:0] pr, bit vt, int gs, bit tp, logic [7:0] sl,
                         bit wd, logic [63:0] wdat, logic [63:0] wm, int tid,
                         output bit err, output logic [63:0] rd, output int pg);
        bit ok;
        logic [63:0] m;
        int n, first, w, kind;
        err = 1'b0; rd = '0; pg = 0; ok = 1'b0;
        if (c == 1) ok = (pr == 2'b11) && !vt;
        else if (pr == 2'b01) begin
            if (vt) begin ok = (gs != 0) && (gs < PAGES); pg = gs; end
            else ok = 1'b1;
        end
        m = wd ? wm : (wm & 64'h0000_0000_FFFF_FFFF);
        if (!ok) begin err = 1'b1; return; end
        if (tp) begin
            rd = 64'(tid);
            if (m != 0 && tid != 0) m_arr[c][0][pg*IDS + tid] = 1'b0;
        end else if (sl == 8'h70) begin
            rd = {63'h0, m_dl[c][pg]};
            if (m[0]) m_dl[c][pg] = wdat[0];
        end else if (sl == 8'h72) begin
            rd = 64'(m_th[c][pg]);
            m_th[c][pg] = (m_th[c][pg] & ~m[ID_W-1:0]) | (wdat[ID_W-1:0] & m[ID_W-1:0]);
        end else if (sl >= 8'h80) begin
            n = int'(sl) % 64;
            kind = (sl >= 8'hC0) ? 1 : 0;
            if (wd) begin
                w = 64;
                if ((n % 2) == 1 || (n / 2) >= IDS / 64) begin err = 1'b1; return; end
                first = (n / 2) * 64;
            end else begin
                w = 32;
                if (n >= IDS / 32) begin err = 1'b1; return; end
                first = n * 32;
            end
            for (int i = 0; i < w; i++) begin
                rd[i] = m_arr[c][kind][pg*IDS + first + i];
                if (m[i] && (first + i) != 0) m_arr[c][kind][pg*IDS + first + i] = wdat[i];
            end
        end else begin
            err = 1'b1;
        end
    endtask

    task automatic chk_state(string req);
        logic [TOTAL-1:0] ep, ee;
        logic [PAGES-1:0] ed;
        logic [PAGES*ID_W-1:0] et;
        for (int c = 0; c < 2; c++) begin
            for (int b = 0; b < TOTAL; b++) begin ep[b] = m_arr[c][0][b]; ee[b] = m_arr[c][1][b]; end
            for (int p = 0; p < PAGES; p++) begin ed[p] = m_dl[c][p]; et[p*ID_W +: ID_W] = m_th[c][p]; end
            if (c == 0) begin
                chk(pd_s == ep, req, "pending state (S)", 64'(pd_s != ep), 64'h0);
                chk(en_s == ee, req, "enable state (S)", 64'(en_s != ee), 64'h0);
                chk(dl_s == ed && th_s == et, req, "deliver/threshold (S)", 64'(th_s), 64'(et));
            end else begin
                chk(pd_m == ep, req, "pending state (M)", 64'(pd_m != ep), 64'h0);
                chk(en_m == ee, req, "enable state (M)", 64'(en_m != ee), 64'h0);
                chk(dl_m == ed && th_m == et, req, "deliver/threshold (M)", 64'(th_m), 64'(et));
            end
        end
    endtask

    task automatic acc(string req, logic [1:0] pr, bit vt, int gs, bit tp, logic [7:0] sl,
                       bit wd, logic [63:0] wdat, logic [63:0] wm, int tid);
        bit e_err [2];
        logic [63:0] e_rd [2];
        int e_pg [2];
        @(negedge clk);
        req_valid = 1'b1; req_priv = pr; req_virt = vt; req_guest = GUEST_W'(gs);
        req_top = tp; req_sel = sl; req_wide = wd; req_wdata = wdat; req_wmask = wm;
        top_id = IDX_W'(tid);
        for (int c = 0; c < 2; c++) model(c, pr, vt, gs, tp, sl, wd, wdat, wm, tid, e_err[c], e_rd[c], e_pg[c]);
        #1;
        if (!e_err[0]) chk(int'(page_s) == e_pg[0], req, "page_o (S)", 64'(page_s), 64'(e_pg[0]));
        if (!e_err[1]) chk(int'(page_m) == e_pg[1], req, "page_o (M)", 64'(page_m), 64'(e_pg[1]));
        @(posedge clk); #1;
        chk(rv_s == 1'b1 && rv_m == 1'b1, "R11", "rsp_valid", {62'h0, rv_s, rv_m}, 64'h3);
        chk(re_s == e_err[0], req, "rsp_err (S)", 64'(re_s), 64'(e_err[0]));
        chk(re_m == e_err[1], req, "rsp_err (M)", 64'(re_m), 64'(e_err[1]));
        chk(rd_s == e_rd[0], req, "rsp_rdata (S)", rd_s, e_rd[0]);
        chk(rd_m == e_rd[1], req, "rsp_rdata (M)", rd_m, e_rd[1]);
        chk_state(req);
    endtask

    task automatic idle(string req);
        @(negedge clk);
        req_valid = 1'b0;
        req_wmask = {$urandom, $urandom};
        @(posedge clk); #1;
        chk(rv_s == 1'b0 && rv_m == 1'b0, req, "rsp_valid idle", {62'h0, rv_s, rv_m}, 64'h0);
        chk_state(req);
    endtask

    localparam logic [1:0] S = 2'b01, M = 2'b11, U = 2'b00;
    localparam logic [63:0] ALL = 64'hFFFF_FFFF_FFFF_FFFF;

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        // R12 reset state
        chk(rv_s == 1'b0 && rv_m == 1'b0, "R12", "rsp_valid after reset", {62'h0, rv_s, rv_m}, 64'h0);
        chk(pd_s == '0 && en_s == '0 && dl_s == '0 && th_s == '0, "R12", "S state after reset",
            64'(|{pd_s, en_s, dl_s, th_s}), 64'h0);
        chk(pd_m == '0 && en_m == '0 && dl_m == '0 && th_m == '0, "R12", "M state after reset",
            64'(|{pd_m, en_m, dl_m, th_m}), 64'h0);

        // R4 delivery and threshold, R8 old value then masked write
        acc("R4", S, 0, 0, 0, 8'h70, 0, 64'h1, 64'h1, 0);
        acc("R8", S, 0, 0, 0, 8'h70, 0, 64'h0, 64'h0, 0);
        acc("R4", S, 0, 0, 0, 8'h72, 0, 64'hFF, 64'h0F, 0);
        acc("R8", S, 0, 0, 0, 8'h72, 0, 64'h30, 64'hF0, 0);
        acc("R4", S, 0, 0, 0, 8'h71, 0, ALL, ALL, 0);
        acc("R4", S, 0, 0, 0, 8'h00, 1, ALL, ALL, 0);
        // R1 / R2 privilege handling
        acc("R1", M, 0, 0, 0, 8'h70, 0, 64'h1, 64'h1, 0);
        acc("R1", M, 1, 0, 0, 8'h70, 0, 64'h1, 64'h1, 0);
        acc("R2", U, 0, 0, 0, 8'h70, 0, 64'h1, 64'h1, 0);
        acc("R2", S, 0, 0, 0, 8'h72, 0, 64'h0, 64'h0, 0);
        // R3 guest pages
        acc("R3", S, 1, 2, 0, 8'h70, 0, 64'h1, 64'h1, 0);
        acc("R3", S, 1, 3, 0, 8'h72, 0, 64'h55, ALL, 0);
        acc("R3", S, 1, 0, 0, 8'h70, 0, 64'h1, 64'h1, 0);
        acc("R3", S, 1, PAGES, 0, 8'h70, 0, 64'h1, 64'h1, 0);
        // R5 narrow array words
        acc("R5", S, 0, 0, 0, 8'h81, 0, 64'hDEAD_BEEF, 64'hFFFF_FFFF, 0);
        acc("R5", S, 0, 0, 0, 8'h81, 0, 64'h0, 64'h0, 0);
        acc("R5", S, 1, 1, 0, 8'hC3, 0, 64'h8000_0001, 64'hFFFF_FFFF, 0);
        acc("R5", S, 1, 1, 0, 8'hC3, 0, 64'h0, 64'h0, 0);
        // R6 wide array words
        acc("R6", S, 0, 0, 0, 8'h82, 1, 64'h0123_4567_89AB_CDEF, ALL, 0);
        acc("R6", S, 0, 0, 0, 8'h82, 1, 64'h0, 64'h0, 0);
        acc("R6", S, 0, 0, 0, 8'h81, 1, ALL, ALL, 0);
        acc("R6", M, 0, 0, 0, 8'hC2, 1, ALL, ALL, 0);
        // R7 index limits
        acc("R7", S, 0, 0, 0, 8'h84, 0, ALL, ALL, 0);
        acc("R7", S, 0, 0, 0, 8'h84, 1, ALL, ALL, 0);
        acc("R7", S, 0, 0, 0, 8'h83, 0, ALL, ALL, 0);
        // R8 partial masks
        acc("R8", S, 0, 0, 0, 8'h80, 0, 64'h0000_F0F0, 64'h0000_FF00, 0);
        acc("R8", S, 0, 0, 0, 8'h80, 0, 64'h0, 64'h0, 0);
        // R9 identity 0
        acc("R9", S, 0, 0, 0, 8'h80, 1, ALL, ALL, 0);
        acc("R9", S, 0, 0, 0, 8'hC0, 0, ALL, ALL, 0);
        acc("R9", S, 0, 0, 0, 8'hC0, 0, 64'h0, 64'h0, 0);
        // R10 top port
        acc("R10", S, 0, 0, 1, 8'h00, 0, 64'h0, 64'h0, 5);
        acc("R10", S, 0, 0, 1, 8'h71, 0, 64'h0, 64'h2, 5);
        acc("R10", S, 0, 0, 1, 8'h70, 0, 64'h0, ALL, 0);
        acc("R10", S, 1, 1, 1, 8'h00, 1, 64'h0, 64'h1_0000_0000, 63);
        acc("R10", S, 0, 0, 1, 8'h00, 0, 64'h0, 64'h1_0000_0000, 6);
        acc("R10", M, 0, 0, 1, 8'h00, 0, 64'h0, 64'h1, 127);
        // R11 narrow access drops upper mask, response timing
        acc("R11", S, 0, 0, 0, 8'h83, 0, ALL, 64'hFFFF_FFFF_0000_0000, 0);
        acc("R11", M, 0, 0, 0, 8'hC1, 0, ALL, ALL, 0);
        idle("R11");
        idle("R11");

        // Mixed patterns across all rules
        for (int k = 0; k < 400; k++) begin
            logic [7:0] sl;
            int pick = $urandom_range(0, 9);
            if (pick == 0)      sl = 8'h70;
            else if (pick == 1) sl = 8'h72;
            else if (pick == 2) sl = 8'(($urandom_range(0, 127)));
            else                sl = 8'h80 + 8'($urandom_range(0, 127));
            acc("R8", 2'($urandom_range(0, 3)), bit'($urandom_range(0, 1)), $urandom_range(0, 5),
                ($urandom_range(0, 7) == 0), sl, bit'($urandom_range(0, 1)),
                {$urandom, $urandom}, {$urandom, $urandom}, $urandom_range(0, IDS - 1));
            if ($urandom_range(0, 9) == 0) idle("R11");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule